// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address for each beat of a four-beat burst to a synchronous burst memory. A start strobe captures a full external address as the burst base. Each later advance strobe moves the burst to its next beat. Only the two least significant address bits change from beat to beat. The upper bits are held at the value captured when the burst started.

The beat order is picked at load time from a single select pin. In linear order the low bits count up modulo four from the base. In interleaved order the low bits are the base low bits XOR the beat number. In both orders the fourth advance brings the address back to the starting offset, not to zero.

There are two start strobes, and either one alone or both together begin a burst. A new address may be loaded on every clock cycle. The block has no data stream: all pins are plain control or address signals sampled on the rising clock edge, so no valid/ready handshake and no back-pressure apply.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (rst_n low) is applied, and after it is released with no strobe, addr_out is all zeros and the order is linear.
- R2: When start_a or start_b is high at a rising edge, addr_out equals the addr_in value sampled at that edge, from just after the edge onward.
- R3: start_a alone, start_b alone, and both together each start a burst in the same way.
- R4: In linear order (order_sel = 0 at load), after n advances the low two bits are (base low bits + n) mod 4.
- R5: In interleaved order (order_sel = 1 at load), after n advances the low two bits are the base low bits XOR (n mod 4).
- R6: order_sel is taken only on a load edge; changing it during a burst has no effect on the sequence.
- R7: When no start strobe and no adv are high at an edge, addr_out keeps its value.
- R8: When a start strobe and adv are high together, the load wins and the beat count restarts at zero.
- R9: The upper address bits stay at their loaded value for the whole burst; addr_in is ignored at edges without a start strobe.
- R10: On the fourth advance after a load, addr_out returns to the loaded address.
- R11: Loads on consecutive cycles each take effect with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address captured on a start |
| start_a | input | 1 | First burst-start strobe |
| start_b | input | 1 | Second burst-start strobe |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 = linear, 1 = interleaved; taken at load |
| addr_out | output | ADDR_W | Current beat address |

## Verification
Each result is due exactly one rising edge after the stimulus that causes it. A load, an advance or a hold is registered at that edge, and addr_out follows combinationally from the registered state. The bench drives every stimulus on the falling edge. It then waits for the next rising edge and samples addr_out 1 ns later, so each check falls in the cycle right after its stimulus. Reset is checked while it is applied and again after release, before any strobe arrives.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] base,
  output burst_order_e      order_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      order_q <= ORD_LINEAR;
    end else if (load) begin
      base    <= addr_in;
      order_q <= burst_order_e'(order_sel);
    end
  end

  // R2: a load captures the address presented at that edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> base == $past(addr_in));
  // R9 / R6: without a load, base and order are frozen
  a_r9_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base) && $stable(order_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      beat <= '0;
    else if (load)
      beat <= '0;
    else if (adv)
      beat <= beat + 1'b1;
  end

  // R8: a load, even with adv high, restarts the beat count
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat == '0);
  // R7: no load and no advance keeps the beat
  a_r7_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(beat));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  logic [BEAT_W-1:0] base_lo,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] lo_out
);
  always_comb begin
    if (order == ORD_INTERLEAVE)
      lo_out = base_lo ^ beat;   // R5
    else
      lo_out = base_lo + beat;   // R4, wraps modulo 4
  end

  // R5 / R4: beat zero always maps to the base offset
  always_comb begin
    a_r10_beat0_base: assert (beat != '0 || lo_out == base_lo);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_a,
  input  logic              start_b,
  input  logic              adv,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo;

  assign load = start_a | start_b;   // R3

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
    .order_sel(order_sel), .base(base), .order_q(order_q)
  );

  burst_beat_ctr u_beat (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .beat(beat)
  );

  burst_order_map u_map (
    .base_lo(base[BEAT_W-1:0]), .beat(beat), .order(order_q), .lo_out(lo)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_out = {base[ADDR_W-1:BEAT_W], lo};
    end else begin : g_lo_only
      assign addr_out = lo[ADDR_W-1:0];
    end
  endgenerate

  // R7: idle edges leave the output alone
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b && !adv) |=> $stable(addr_out));
  // R9: upper bits never move without a load
  a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
  // R2 / R3: either strobe puts addr_in on the output next cycle
  a_r3_either_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a || start_b) |=> addr_out == $past(addr_in));
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int AW = 20;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          start_a = 1'b0, start_b = 1'b0, adv = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  int            n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .start_a(start_a),
    .start_b(start_b), .adv(adv), .order_sel(order_sel), .addr_out(addr_out)
  );

  // {req[3:0], start_a, start_b, adv, order_sel, addr_in[19:0], expect[19:0]}
  localparam logic [47:0] VEC [NV] = '{
    {4'd2,  4'b1000, 20'h12346, 20'h12346}, // R2 start_a, linear, low 10
    {4'd4,  4'b0010, 20'h00000, 20'h12347}, // R4 step to 11
    {4'd4,  4'b0010, 20'h00000, 20'h12344}, // R4 wrap mod 4 to 00
    {4'd9,  4'b0010, 20'h99999, 20'h12345}, // R9 addr_in ignored
    {4'd10, 4'b0010, 20'h00000, 20'h12346}, // R10 back to start
    {4'd7,  4'b0000, 20'h00000, 20'h12346}, // R7 hold
    {4'd3,  4'b0101, 20'hABCD1, 20'hABCD1}, // R3 start_b, interleaved, low 01
    {4'd6,  4'b0010, 20'h55555, 20'hABCD0}, // R6 order_sel low mid-burst ignored
    {4'd5,  4'b0011, 20'h00000, 20'hABCD3}, // R5 01^10
    {4'd5,  4'b0010, 20'h00000, 20'hABCD2}, // R5 01^11
    {4'd10, 4'b0010, 20'h00000, 20'hABCD1}, // R10 interleaved wrap
    {4'd8,  4'b1011, 20'h0000E, 20'h0000E}, // R8 start with adv: load wins
    {4'd8,  4'b0010, 20'h00000, 20'h0000F}, // R8 beat 1: 10^01
    {4'd3,  4'b1100, 20'hFFFFF, 20'hFFFFF}, // R3 both strobes
    {4'd4,  4'b0010, 20'h00000, 20'hFFFFC}, // R4 11+1 -> 00, upper kept
    {4'd11, 4'b1001, 20'h00003, 20'h00003}, // R11 back-to-back load
    {4'd11, 4'b0100, 20'h80000, 20'h80000}, // R11 back-to-back load
    {4'd4,  4'b0010, 20'h00000, 20'h80001}, // R4
    {4'd5,  4'b1001, 20'h7000B, 20'h7000B}, // R5 interleaved from 11
    {4'd5,  4'b0010, 20'h00000, 20'h7000A}, // R5 11^01
    {4'd5,  4'b0010, 20'h00000, 20'h70009}, // R5 11^10
    {4'd5,  4'b0010, 20'h00000, 20'h70008}  // R5 11^11
  };

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_cmp++;
    if (addr_out !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, held and after release
    addr_in = 20'hFFFFF; start_a = 1'b1;
    step();
    check("R1", '0);
    @(negedge clk);
    rst_n = 1'b1; start_a = 1'b0;
    step();
    check("R1", '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {start_a, start_b, adv, order_sel} = VEC[i][43:40];
      addr_in = VEC[i][39:20];
      step();
      n_cmp++;
      if (addr_out !== VEC[i][19:0]) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: addr_out=%h expected=%h",
                 VEC[i][47:44], i, addr_out, VEC[i][19:0]);
      end
    end

    // R7: long idle with addr_in and order_sel toggling keeps the output
    @(negedge clk);
    {start_a, start_b, adv} = 3'b000;
    for (int k = 0; k < 3; k++) begin
      addr_in = 20'h0F0F0 ^ AW'(k);
      order_sel = k[0];
      step();
      check("R7", 20'h70008);
      @(negedge clk);
    end

    // R1: asynchronous reset mid-burst clears the output
    rst_n = 1'b0;
    #2;
    check("R1", '0);
    @(negedge clk);
    rst_n = 1'b1;
    adv = 1'b1;
    step();
    check("R1", 20'h00001); // linear after reset
    @(negedge clk);
    adv = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule